// File: doc/BRIEF.md
# Three-Channel Byte-Programmed Interval Timer

This block holds three 16-bit down counters behind an 8-bit register port. Each counter has a reload divider and a mode byte. Software first writes a control byte that picks a counter and its byte access format. It then loads the divider through that counter's data port, one byte at a time. A counter counts only while it is armed and its gate is active. It decrements on each cycle in which the shared tick enable is high. When it reaches terminal count it reloads its divider, so it runs as a periodic rate generator.

Only the middle counter (channel 1) has its gate permanently active. Its terminal count drives a one-cycle clock-interrupt set pulse, unless the inhibit-timers input is high. The other two channels keep their programmed divider but never count. A read of the clear-latch port produces a one-cycle clock-interrupt clear pulse. The interrupt latch itself lives outside this block.

Top module: `ivt_timer`

## Requirements
- R1: A write to the control port (byte offset 0x0C) takes the channel number from data bits 7:6. The value 3 is invalid: the write changes no state at all, including which mode byte the control port reads back.
- R2: A valid control write stores the whole byte as that channel's mode, disarms the channel and resets its byte toggle. A read of the control port returns the mode byte of the channel named by the most recent valid control write. That is channel 0 after reset, and every mode resets to 0x00.
- R3: Mode bits 5:4 select the access format. With 01 (low only) or 10 (high only), one data write replaces that byte of the divider and arms the channel.
- R4: With format 11 (alternating), a data write while the toggle is clear loads the low byte, leaves the armed state as it was and sets the toggle. A write while the toggle is set loads the high byte, arms the channel and clears the toggle.
- R5: With format 00, data writes change nothing and data reads return 0x00.
- R6: Data reads use the same format. Format 01 returns bits 7:0 and format 10 returns bits 15:8. Format 11 returns the low byte while the toggle is clear and the high byte while it is set, and each read flips the same toggle that writes use.
- R7: A data read sees the live count when the channel is armed and its gate is active (channel 1 only). Otherwise it sees the programmed divider.
- R8: An armed channel 1 decrements on each tick. On a tick at count 1 it reloads its divider, so terminal count recurs every divider ticks. A divider of 0 gives 65536 ticks. The write that arms a channel loads the count from the new divider, and that load takes priority over a tick in the same cycle.
- R9: `clk_irq_set` is high for exactly the one cycle after each channel 1 terminal-count tick during which `inhibit_timers` was low, and is low at all other times.
- R10: A read of the clear-latch port (offset 0x10) returns 0x00 and makes `clk_irq_clr` high for the following cycle only. A write to that port has no effect.
- R11: Channels 0, 1 and 2 have data ports at offsets 0x00, 0x04 and 0x08. A read of any other address returns 0x00, and a write to one changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable shared by all channels |
| inhibit_timers | input | 1 | Suppresses clock-interrupt set pulses |
| bus_addr | input | ADDR_W (5) | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| clk_irq_set | output | 1 | One-cycle clock-interrupt set pulse |
| clk_irq_clr | output | 1 | One-cycle clock-interrupt clear pulse |

## Verification
The hardest case to reach is the 65536-tick period of a zero divider. It needs channel 1 armed with both divider bytes at zero and the tick held high for more than 65536 cycles, with the set pulse checked on every one of them. A directed phase reaches it in low-only format, after the alternating phase has left the high byte at zero. Random traffic then mixes reads and writes in the alternating format with ticks. This shows whether reads and writes really share one toggle, and whether a low-byte write on an armed channel leaves the count running.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   localparam int BYTE_W      = 8;
   localparam int NUM_CH      = 3;
   localparam int PORT_STRIDE = 4;
   localparam int CTL_OFS     = NUM_CH * PORT_STRIDE;
   localparam int CLR_OFS     = (NUM_CH + 1) * PORT_STRIDE;

   typedef enum logic [1:0] {
      FMT_NONE = 2'b00,
      FMT_LO   = 2'b01,
      FMT_HI   = 2'b10,
      FMT_ALT  = 2'b11
   } acc_fmt_e;
endpackage

// File: rtl/ivt_channel.sv
module ivt_channel
   import ivt_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter bit GATED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ctl_wr,
   input  logic              data_wr,
   input  logic              data_rd,
   input  logic [BYTE_W-1:0] wr_byte,
   output logic [BYTE_W-1:0] rd_byte,
   output logic [BYTE_W-1:0] mode_o,
   output logic              term_o
);
   localparam int HI_LSB = CNT_W - BYTE_W;

   initial begin
      assert (CNT_W == 2 * BYTE_W)
         else $error("ivt_channel: CNT_W must hold exactly two bytes");
   end

   logic [BYTE_W-1:0] mode_q;
   logic [CNT_W-1:0]  div_q, div_nx, cur;
   logic              armed_q, tog_q, arm_now;
   acc_fmt_e          fmt;

   assign fmt    = acc_fmt_e'(mode_q[5:4]);
   assign mode_o = mode_q;

   // next divider and arming decision for a data write
   always_comb begin
      div_nx  = div_q;
      arm_now = 1'b0;
      if (data_wr) begin
         unique case (fmt)
            FMT_LO: begin
               div_nx[BYTE_W-1:0] = wr_byte;
               arm_now = 1'b1;
            end
            FMT_HI: begin
               div_nx[CNT_W-1:HI_LSB] = wr_byte;
               arm_now = 1'b1;
            end
            FMT_ALT: begin
               if (tog_q) begin
                  div_nx[CNT_W-1:HI_LSB] = wr_byte;
                  arm_now = 1'b1;
               end else begin
                  div_nx[BYTE_W-1:0] = wr_byte;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= '0;
         div_q   <= '0;
         armed_q <= 1'b0;
         tog_q   <= 1'b0;
      end else if (ctl_wr) begin
         mode_q  <= wr_byte;
         armed_q <= 1'b0;
         tog_q   <= 1'b0;
      end else begin
         if (data_wr) begin
            div_q <= div_nx;
            if (arm_now) armed_q <= 1'b1;
         end
         if ((data_wr || data_rd) && fmt == FMT_ALT) tog_q <= ~tog_q;
      end
   end

   generate
      if (GATED) begin : g_live
         logic [CNT_W-1:0] cnt_q;
         logic             hit;

         assign hit = tick & armed_q & ~ctl_wr & ~arm_now & (cnt_q == CNT_W'(1));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (ctl_wr) begin
               cnt_q <= cnt_q;
            end else if (arm_now) begin
               cnt_q <= div_nx;
            end else if (tick && armed_q) begin
               cnt_q <= (cnt_q == CNT_W'(1)) ? div_q : cnt_q - CNT_W'(1);
            end
         end

         assign cur    = armed_q ? cnt_q : div_q;
         assign term_o = hit;

         // R8: terminal tick reloads the divider
         a_r8_reload : assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> cnt_q == $past(div_q));
         // R8: arming write takes priority over a tick
         a_r8_arm_load : assert property (@(posedge clk) disable iff (!rst_n)
            (arm_now && !ctl_wr) |=> (armed_q && cnt_q == $past(div_nx)));
         // R8: a disarmed channel holds its count
         a_r8_hold : assert property (@(posedge clk) disable iff (!rst_n)
            (!armed_q && !arm_now) |=> $stable(cnt_q));
      end else begin : g_static
         logic unused_tick;
         assign unused_tick = tick;
         assign cur    = div_q;
         assign term_o = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (fmt)
         FMT_LO:  rd_byte = cur[BYTE_W-1:0];
         FMT_HI:  rd_byte = cur[CNT_W-1:HI_LSB];
         FMT_ALT: rd_byte = tog_q ? cur[CNT_W-1:HI_LSB] : cur[BYTE_W-1:0];
         default: rd_byte = '0;
      endcase
   end

   // R2: a control write disarms and clears the toggle
   a_r2_ctl_disarms : assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (!armed_q && !tog_q && mode_q == $past(wr_byte)));
   // R4: the first half of an alternating load does not arm
   a_r4_low_no_arm : assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !ctl_wr && fmt == FMT_ALT && !tog_q && !armed_q) |=> !armed_q);
   // R5: format none ignores data writes
   a_r5_none_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !ctl_wr && fmt == FMT_NONE) |=> ($stable(div_q) && $stable(armed_q)));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
   import ivt_pkg::*;
#(
   parameter int          ADDR_W    = 5,
   parameter int          CNT_W     = 16,
   parameter logic [2:0]  GATE_MASK = 3'b010,
   parameter int          IRQ_CH    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              inhibit_timers,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              clk_irq_set,
   output logic              clk_irq_clr
);
   localparam int SEL_W = 2;

   initial begin
      assert ((1 << ADDR_W) > CLR_OFS)
         else $error("ivt_timer: ADDR_W too narrow for the port map");
      assert (IRQ_CH >= 0 && IRQ_CH < NUM_CH)
         else $error("ivt_timer: IRQ_CH out of range");
      assert (GATE_MASK[IRQ_CH])
         else $error("ivt_timer: interrupt channel must be gated");
   end

   logic [NUM_CH-1:0] is_data, ch_term;
   logic              is_ctl, is_clr;
   logic [SEL_W-1:0]  ctl_sel, last_sel;
   logic [BYTE_W-1:0] ch_rd   [NUM_CH];
   logic [BYTE_W-1:0] ch_mode [NUM_CH];

   assign is_ctl  = (bus_addr == ADDR_W'(CTL_OFS));
   assign is_clr  = (bus_addr == ADDR_W'(CLR_OFS));
   assign ctl_sel = bus_wdata[7:6];

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         assign is_data[i] = (bus_addr == ADDR_W'(i * PORT_STRIDE));

         ivt_channel #(
            .CNT_W (CNT_W),
            .GATED (GATE_MASK[i])
         ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick_en),
            .ctl_wr  (bus_wr & is_ctl & (ctl_sel == SEL_W'(i))),
            .data_wr (bus_wr & is_data[i]),
            .data_rd (bus_rd & is_data[i]),
            .wr_byte (bus_wdata),
            .rd_byte (ch_rd[i]),
            .mode_o  (ch_mode[i]),
            .term_o  (ch_term[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_sel    <= '0;
         clk_irq_set <= 1'b0;
         clk_irq_clr <= 1'b0;
      end else begin
         if (bus_wr && is_ctl && ctl_sel < SEL_W'(NUM_CH)) last_sel <= ctl_sel;
         clk_irq_set <= ch_term[IRQ_CH] & ~inhibit_timers;
         clk_irq_clr <= bus_rd & is_clr;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (is_data[i]) bus_rdata = ch_rd[i];
         end
         if (is_ctl) bus_rdata = ch_mode[last_sel];
      end
   end

   logic unused_terms;
   assign unused_terms = ^ch_term;

   // R1: invalid channel number leaves every mode and the readback pointer alone
   a_r1_bad_sel : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && is_ctl && ctl_sel == 2'b11) |=>
         ($stable(ch_mode[0]) && $stable(ch_mode[1]) && $stable(ch_mode[2]) && $stable(last_sel)));
   // R9: a set pulse only follows a terminal tick with inhibit low
   a_r9_set_cause : assert property (@(posedge clk) disable iff (!rst_n)
      clk_irq_set |-> $past(ch_term[IRQ_CH] && !inhibit_timers));
   // R9: inhibit blocks the pulse
   a_r9_inhibit : assert property (@(posedge clk) disable iff (!rst_n)
      inhibit_timers |=> !clk_irq_set);
   // R10: clear pulse only follows a clear-latch read
   a_r10_clr_cause : assert property (@(posedge clk) disable iff (!rst_n)
      clk_irq_clr |-> $past(bus_rd && is_clr));
   // R10: clear-latch read returns zero
   a_r10_clr_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && is_clr) |-> bus_rdata == 8'h00);
endmodule

// File: tb/sim_ivt_timer.sv
module sim_ivt_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0, inhibit_timers = 1'b0;
   logic [4:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       clk_irq_set, clk_irq_clr;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ivt_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .inhibit_timers(inhibit_timers),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .clk_irq_set(clk_irq_set), .clk_irq_clr(clk_irq_clr)
   );

   // reference model
   logic [7:0]  m_mode [3];
   logic [15:0] m_div  [3];
   bit          m_arm  [3];
   bit          m_tog  [3];
   logic [15:0] m_cnt;
   int          m_last;
   bit          exp_set = 0, exp_clr = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_read(input logic [4:0] a, output logic [7:0] v, output string tag);
      v = 8'h00;
      tag = "R11";
      if (a == 5'd0 || a == 5'd4 || a == 5'd8) begin
         int ch;
         logic [15:0] cur;
         ch  = a / 4;
         cur = (m_arm[ch] && ch == 1) ? m_cnt : m_div[ch];
         tag = "R6 R7";
         case (m_mode[ch][5:4])
            2'b01: v = cur[7:0];
            2'b10: v = cur[15:8];
            2'b11: begin
               v = m_tog[ch] ? cur[15:8] : cur[7:0];
               m_tog[ch] = ~m_tog[ch];
            end
            default: begin v = 8'h00; tag = "R5"; end
         endcase
      end else if (a == 5'd12) begin
         v = m_mode[m_last];
         tag = "R2";
      end else if (a == 5'd16) begin
         tag = "R10";
      end
   endtask

   task automatic model_write(input logic [4:0] a, input logic [7:0] d,
                              output bit ctl_b, output bit arm_b);
      ctl_b = 0;
      arm_b = 0;
      if (a == 5'd12) begin
         int s;
         s = d[7:6];
         if (s != 3) begin
            m_mode[s] = d;
            m_arm[s]  = 0;
            m_tog[s]  = 0;
            m_last    = s;
            if (s == 1) ctl_b = 1;
         end
      end else if (a == 5'd0 || a == 5'd4 || a == 5'd8) begin
         int ch;
         bit armed_now;
         ch = a / 4;
         armed_now = 0;
         case (m_mode[ch][5:4])
            2'b01: begin m_div[ch][7:0] = d; armed_now = 1; end
            2'b10: begin m_div[ch][15:8] = d; armed_now = 1; end
            2'b11: begin
               if (m_tog[ch]) begin m_div[ch][15:8] = d; armed_now = 1; end
               else m_div[ch][7:0] = d;
               m_tog[ch] = ~m_tog[ch];
            end
            default: ;
         endcase
         if (armed_now) m_arm[ch] = 1;
         if (ch == 1) arm_b = armed_now;
      end
   endtask

   // one bus cycle; called and returns at a falling edge
   task automatic op(input bit we, input bit re, input logic [4:0] a, input logic [7:0] d,
                     input bit tk, input string tag_in);
      logic [7:0]  ev;
      string       tag;
      bit          ctl_b, arm_b, old_arm, hit;
      logic [15:0] old_div, old_cnt;
      check(clk_irq_set === exp_set, "R8 R9 set pulse", clk_irq_set, exp_set);
      check(clk_irq_clr === exp_clr, "R10 clear pulse", clk_irq_clr, exp_clr);
      bus_wr = we; bus_rd = re; bus_addr = a; bus_wdata = d; tick_en = tk;
      #1;
      if (re) begin
         model_read(a, ev, tag);
         if (tag_in != "") tag = tag_in;
         check(bus_rdata === ev, tag, bus_rdata, ev);
      end
      old_arm = m_arm[1]; old_div = m_div[1]; old_cnt = m_cnt;
      ctl_b = 0; arm_b = 0;
      if (we) model_write(a, d, ctl_b, arm_b);
      hit = tk && old_arm && !ctl_b && !arm_b && old_cnt == 16'd1;
      if (!ctl_b) begin
         if (arm_b) m_cnt = m_div[1];
         else if (tk && old_arm) m_cnt = (old_cnt == 16'd1) ? old_div : old_cnt - 16'd1;
      end
      exp_set = hit && !inhibit_timers;
      exp_clr = re && a == 5'd16;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; tick_en = 0;
   endtask

   initial begin
      #1_520_000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int gap;
      void'($urandom(32'h0000_5eed));
      for (int i = 0; i < 3; i++) begin
         m_mode[i] = 0; m_div[i] = 0; m_arm[i] = 0; m_tog[i] = 0;
      end
      m_cnt = 0; m_last = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // reset state
      op(0, 1, 5'd12, 0, 0, "R2 reset mode");
      op(0, 1, 5'd4, 0, 0, "R5 reset data");
      // R1: invalid select leaves readback pointer and modes alone
      op(1, 0, 5'd12, 8'h90, 0, "");
      op(1, 0, 5'd12, 8'hD0, 0, "");
      op(0, 1, 5'd12, 0, 0, "R1 invalid select ignored");
      // R3: low only and high only on channel 2
      op(1, 0, 5'd8, 8'h42, 0, "");
      op(0, 1, 5'd8, 0, 0, "R3 low byte");
      op(1, 0, 5'd12, 8'hA0, 0, "");
      op(1, 0, 5'd8, 8'h17, 0, "");
      op(0, 1, 5'd8, 0, 0, "R3 high byte");
      // R5: format none on channel 0 ignores writes
      op(1, 0, 5'd12, 8'h00, 0, "");
      op(1, 0, 5'd0, 8'h5A, 0, "");
      op(1, 0, 5'd12, 8'h10, 0, "");
      op(0, 1, 5'd0, 0, 0, "R5 write ignored");
      // R4: alternating load on channel 1, low half does not arm
      op(1, 0, 5'd12, 8'h70, 0, "");
      op(1, 0, 5'd4, 8'h03, 1, "");
      op(0, 0, 5'd0, 0, 1, "");
      op(1, 0, 5'd4, 8'h00, 0, "");
      op(0, 1, 5'd4, 0, 0, "R4 armed low");
      op(0, 0, 5'd0, 0, 1, "");
      op(0, 1, 5'd4, 0, 0, "R4 R7 live high");
      for (int i = 0; i < 12; i++) op(0, 0, 5'd0, 0, 1, "");
      // R9: inhibit
      inhibit_timers = 1;
      for (int i = 0; i < 8; i++) op(0, 0, 5'd0, 0, 1, "");
      inhibit_timers = 0;
      for (int i = 0; i < 6; i++) op(0, 0, 5'd0, 0, 1, "");
      // R10: clear latch write does nothing, read pulses
      op(1, 0, 5'd16, 8'hFF, 0, "");
      op(0, 1, 5'd16, 0, 0, "R10 clear read zero");
      op(0, 0, 5'd0, 0, 0, "");
      // R11: unmapped address
      op(1, 0, 5'd20, 8'h33, 0, "");
      op(0, 1, 5'd20, 0, 0, "R11 unmapped read");
      // R8: divider zero gives 65536 ticks
      op(1, 0, 5'd12, 8'h50, 0, "");
      op(1, 0, 5'd4, 8'h00, 0, "");
      op(0, 0, 5'd0, 0, 1, "");
      op(0, 1, 5'd4, 0, 0, "R8 zero divider wraps");
      gap = 1;
      while (!clk_irq_set && gap < 70000) begin
         op(0, 0, 5'd0, 0, 1, "");
         gap++;
      end
      check(gap == 65536, "R8 zero divider period", gap, 65536);

      // constrained random traffic
      for (int n = 0; n < 5000; n++) begin
         int k;
         logic [4:0] a;
         logic [7:0] d;
         k = $urandom % 8;
         a = (k == 7) ? 5'($urandom) : 5'((k % 5) * 4);
         d = ($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 4);
         if (a == 5'd12 && ($urandom % 2 == 0)) d[7:6] = 2'b01;
         if ($urandom % 16 == 0) inhibit_timers = ~inhibit_timers;
         case ($urandom % 3)
            0: op(1, 0, a, d, 1'($urandom), "");
            1: op(0, 1, a, 0, 1'($urandom), "");
            default: op(0, 0, 5'd0, 0, 1'($urandom), "");
         endcase
      end
      op(0, 0, 5'd0, 0, 0, "");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule